// File: doc/BRIEF.md
# Video Memory Write Port Decoder

This block handles the write side of the data port of a tile-based video processor. A host places a byte on the port together with a one-cycle strobe. The block uses the current video address to send the byte to one of three targets. Low addresses go to pattern (tile) RAM. The middle range goes to a 4 KB nametable RAM, which is reached through four remappable 1 KB windows. The top range goes to a 32-entry palette that lives inside the block. Pattern and nametable writes leave the block as write commands for external synchronous RAMs, each with one write port.

After every data write, the stored video address moves forward by 1 or by 32. A mode bit that the host loads sets the step. The host can also load the address directly and set the bank number of each nametable window. A sticky flag records whether any palette write actually changed a stored value, and a start-of-frame pulse clears it. The flag lets downstream colour logic skip work when the palette has not changed.

Top module: `vmem_port_decoder`

## Requirements
- R1: After reset, vaddr is 0, the step is 1, windows 0..3 hold banks 0, 0, 1, 1, all palette entries hold 0, pal_changed is low and no write strobe is active.
- R2: addr_ld loads vaddr from addr_in. Otherwise each cycle with wr_en advances vaddr by 32 if the last step_ld carried step_sel=1, or by 1 if it carried step_sel=0. vaddr is 16 bits, is never masked and wraps modulo 65536. With neither addr_ld nor wr_en, vaddr holds.
- R3: Decoding uses only vaddr[13:0]. Below 0x2000, a write raises pat_we with pat_addr = vaddr[12:0] and mem_wdata = wr_data.
- R4: From 0x2000 to 0x3EFF, a write raises nt_we with nt_addr = {bank of window vaddr[11:10], vaddr[9:0]} (12 bits) and mem_wdata = wr_data.
- R5: win_ld sets the bank number (2 bits) of window win_sel to win_bank. This takes effect for writes in later cycles.
- R6: From 0x3F00 up, a write raises pal_we with pal_wdata = wr_data[5:0]. pal_idx is vaddr[4:0], except that bit 4 is cleared when bits 1:0 are zero, so 0x10/0x14/0x18/0x1C share storage with 0x00/0x04/0x08/0x0C.
- R7: At most one of pat_we, nt_we and pal_we is high, and each is high only in a cycle with wr_en.
- R8: pal_changed rises at the edge that ends a palette write whose 6-bit value differs from the entry's stored value. It stays high until frame_start. A differing write in the same cycle as frame_start leaves it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_ld | input | 1 | Load the video address |
| addr_in | input | 16 | Address value to load |
| step_ld | input | 1 | Load the step mode |
| step_sel | input | 1 | 1 selects a step of 32, 0 a step of 1 |
| win_ld | input | 1 | Load one nametable window |
| win_sel | input | 2 | Window number |
| win_bank | input | 2 | Bank number for the window |
| wr_en | input | 1 | Data-port write strobe |
| wr_data | input | 8 | Data-port byte |
| frame_start | input | 1 | Clears the palette-changed flag |
| vaddr | output | 16 | Current video address |
| pat_we | output | 1 | Pattern RAM write enable |
| pat_addr | output | 13 | Pattern RAM address |
| nt_we | output | 1 | Nametable RAM write enable |
| nt_addr | output | 12 | Nametable RAM address |
| mem_wdata | output | 8 | Write data for pattern and nametable RAM |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | 5 | Palette entry after aliasing |
| pal_wdata | output | 6 | Palette value written |
| pal_changed | output | 1 | Sticky palette-changed flag |

## Verification
The address-step properties assume addr_ld and wr_en are never high in the same cycle. Under that assumption, every data write is followed by exactly one advance. The bench never drives both strobes together, and it changes all inputs on the falling clock edge. The properties also assume that no input carries an unknown value after reset, and the bench drives every input to a known level before reset is released.

// File: rtl/vpd_pkg.sv
package vpd_pkg;

  localparam int DEC_W       = 14;
  localparam logic [DEC_W-1:0] NT_BASE  = 14'h2000;
  localparam logic [DEC_W-1:0] PAL_BASE = 14'h3F00;

  typedef enum logic [1:0] {
    RGN_PATTERN = 2'd0,
    RGN_NAMETBL = 2'd1,
    RGN_PALETTE = 2'd2
  } vpd_region_e;

  function automatic vpd_region_e vpd_region(input logic [DEC_W-1:0] a);
    if (a < NT_BASE)       return RGN_PATTERN;
    else if (a < PAL_BASE) return RGN_NAMETBL;
    else                   return RGN_PALETTE;
  endfunction

  function automatic logic [4:0] vpd_pal_index(input logic [4:0] a);
    logic [4:0] idx;
    idx = a;
    if (idx[1:0] == 2'b00) idx[4] = 1'b0;
    return idx;
  endfunction

endpackage

// File: rtl/vpd_addr_gen.sv
module vpd_addr_gen #(
  parameter int ADDR_W   = 16,
  parameter int STEP_BIG = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              step_ld,
  input  logic              step_sel,
  input  logic              adv,
  output logic [ADDR_W-1:0] vaddr,
  output logic              step32
);

  localparam logic [ADDR_W-1:0] STEP_L = ADDR_W'(STEP_BIG);
  localparam logic [ADDR_W-1:0] STEP_S = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              big_q, big_d;

  always_comb begin
    addr_d = addr_q;
    if (addr_ld)  addr_d = addr_in;
    else if (adv) addr_d = addr_q + (big_q ? STEP_L : STEP_S);
  end

  always_comb begin
    big_d = big_q;
    if (step_ld) big_d = step_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      big_q  <= 1'b0;
    end else begin
      if (addr_ld || adv) addr_q <= addr_d;
      if (step_ld)        big_q  <= big_d;
    end
  end

  assign vaddr  = addr_q;
  assign step32 = big_q;

endmodule

// File: rtl/vpd_window_map.sv
module vpd_window_map #(
  parameter int WIN_N  = 4,
  parameter int BANK_W = 2,
  parameter int OFS_W  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       win_ld,
  input  logic [$clog2(WIN_N)-1:0]   win_sel,
  input  logic [BANK_W-1:0]          win_bank,
  input  logic [$clog2(WIN_N)-1:0]   win_idx,
  input  logic [OFS_W-1:0]           ofs,
  output logic [BANK_W+OFS_W-1:0]    nt_addr
);

  logic [BANK_W-1:0] bank_q [WIN_N];

  for (genvar i = 0; i < WIN_N; i++) begin : g_win
    localparam logic [BANK_W-1:0] RST_BANK = BANK_W'(i / 2);
    logic [BANK_W-1:0] bank_d;
    logic              hit;

    assign hit = win_ld && (win_sel == i);

    always_comb begin
      bank_d = bank_q[i];
      if (hit) bank_d = win_bank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank_q[i] <= RST_BANK;
      else if (hit) bank_q[i] <= bank_d;
    end
  end

  assign nt_addr = {bank_q[win_idx], ofs};

endmodule

// File: rtl/vpd_palette.sv
module vpd_palette #(
  parameter int PAL_N = 32,
  parameter int PAL_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [$clog2(PAL_N)-1:0] idx,
  input  logic [PAL_W-1:0]         wdata,
  input  logic                     frame_start,
  output logic                     changed
);

  logic [PAL_W-1:0] ent_q [PAL_N];
  logic             flag_q, flag_d;
  logic             differs;

  assign differs = wr && (ent_q[idx] != wdata);

  for (genvar i = 0; i < PAL_N; i++) begin : g_ent
    logic hit;
    assign hit = wr && (idx == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q[i] <= '0;
      else if (hit) ent_q[i] <= wdata;
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (frame_start) flag_d = 1'b0;
    if (differs)     flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign changed = flag_q;

endmodule

// File: rtl/vmem_port_decoder.sv
module vmem_port_decoder #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int STEP_BIG = 32,
  parameter int PAT_AW   = 13,
  parameter int WIN_N    = 4,
  parameter int BANK_W   = 2,
  parameter int OFS_W    = 10,
  parameter int PAL_N    = 32,
  parameter int PAL_W    = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        addr_ld,
  input  logic [ADDR_W-1:0]           addr_in,
  input  logic                        step_ld,
  input  logic                        step_sel,
  input  logic                        win_ld,
  input  logic [$clog2(WIN_N)-1:0]    win_sel,
  input  logic [BANK_W-1:0]           win_bank,
  input  logic                        wr_en,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        frame_start,
  output logic [ADDR_W-1:0]           vaddr,
  output logic                        pat_we,
  output logic [PAT_AW-1:0]           pat_addr,
  output logic                        nt_we,
  output logic [BANK_W+OFS_W-1:0]     nt_addr,
  output logic [DATA_W-1:0]           mem_wdata,
  output logic                        pal_we,
  output logic [$clog2(PAL_N)-1:0]    pal_idx,
  output logic [PAL_W-1:0]            pal_wdata,
  output logic                        pal_changed
);
  import vpd_pkg::*;

  localparam int WSEL_W = $clog2(WIN_N);
  localparam int PIDX_W = $clog2(PAL_N);

  logic [DEC_W-1:0] dec;
  vpd_region_e      rgn;
  logic             step32;

  assign dec = vaddr[DEC_W-1:0];
  assign rgn = vpd_region(dec);

  vpd_addr_gen #(.ADDR_W(ADDR_W), .STEP_BIG(STEP_BIG)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .step_ld(step_ld), .step_sel(step_sel), .adv(wr_en),
    .vaddr(vaddr), .step32(step32)
  );

  vpd_window_map #(.WIN_N(WIN_N), .BANK_W(BANK_W), .OFS_W(OFS_W)) u_win (
    .clk(clk), .rst_n(rst_n), .win_ld(win_ld), .win_sel(win_sel),
    .win_bank(win_bank), .win_idx(dec[OFS_W+WSEL_W-1:OFS_W]),
    .ofs(dec[OFS_W-1:0]), .nt_addr(nt_addr)
  );

  assign pat_we    = wr_en && (rgn == RGN_PATTERN);
  assign nt_we     = wr_en && (rgn == RGN_NAMETBL);
  assign pal_we    = wr_en && (rgn == RGN_PALETTE);
  assign pat_addr  = dec[PAT_AW-1:0];
  assign mem_wdata = wr_data;
  assign pal_idx   = PIDX_W'(vpd_pal_index(dec[4:0]));
  assign pal_wdata = wr_data[PAL_W-1:0];

  vpd_palette #(.PAL_N(PAL_N), .PAL_W(PAL_W)) u_pal (
    .clk(clk), .rst_n(rst_n), .wr(pal_we), .idx(pal_idx),
    .wdata(pal_wdata), .frame_start(frame_start), .changed(pal_changed)
  );

endmodule

// File: rtl/vpd_checker.sv
module vpd_checker #(
  parameter int ADDR_W   = 16,
  parameter int STEP_BIG = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              addr_ld,
  input logic              frame_start,
  input logic              step32,
  input logic [ADDR_W-1:0] vaddr,
  input logic              pat_we,
  input logic              nt_we,
  input logic              pal_we,
  input logic              pal_changed
);

  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pat_we, nt_we, pal_we}));

  assert_no_strobe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !(pat_we || nt_we || pal_we));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_ld) |=>
      vaddr == ADDR_W'($past(vaddr) + ($past(step32) ? ADDR_W'(STEP_BIG) : ADDR_W'(1))));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !addr_ld) |=> $stable(vaddr));

  assert_pattern_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pat_we |-> (vaddr[13] == 1'b0));

  assert_palette_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> (vaddr[13:8] == 6'h3F));

  assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pal_changed) |-> $past(pal_we));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_changed && !frame_start) |=> pal_changed);

endmodule

bind vmem_port_decoder vpd_checker #(.ADDR_W(ADDR_W), .STEP_BIG(STEP_BIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_ld(addr_ld),
  .frame_start(frame_start), .step32(step32), .vaddr(vaddr),
  .pat_we(pat_we), .nt_we(nt_we), .pal_we(pal_we), .pal_changed(pal_changed)
);

// File: tb/vmem_port_decoder_tb.sv
module vmem_port_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_ld, step_ld, step_sel, win_ld, wr_en, frame_start;
  logic [15:0] addr_in;
  logic [1:0]  win_sel, win_bank;
  logic [7:0]  wr_data;
  logic [15:0] vaddr;
  logic        pat_we, nt_we, pal_we, pal_changed;
  logic [12:0] pat_addr;
  logic [11:0] nt_addr;
  logic [7:0]  mem_wdata;
  logic [4:0]  pal_idx;
  logic [5:0]  pal_wdata;

  int n_tests = 0;
  int n_fail  = 0;

  logic        c_pat, c_nt, c_pal;
  logic [12:0] c_pat_addr;
  logic [11:0] c_nt_addr;
  logic [7:0]  c_wdata;
  logic [4:0]  c_pidx;
  logic [5:0]  c_pdata;

  always #4 clk = ~clk;

  vmem_port_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .step_ld(step_ld), .step_sel(step_sel), .win_ld(win_ld),
    .win_sel(win_sel), .win_bank(win_bank), .wr_en(wr_en),
    .wr_data(wr_data), .frame_start(frame_start), .vaddr(vaddr),
    .pat_we(pat_we), .pat_addr(pat_addr), .nt_we(nt_we), .nt_addr(nt_addr),
    .mem_wdata(mem_wdata), .pal_we(pal_we), .pal_idx(pal_idx),
    .pal_wdata(pal_wdata), .pal_changed(pal_changed)
  );

  // {addr[15:0], data[7:0], region[1:0] (0 pat,1 nt,2 pal), expected target address[15:0]}
  localparam int NV = 13;
  localparam logic [41:0] VEC [NV] = '{
    {16'h0000, 8'hAB, 2'd0, 16'h0000},
    {16'h1FFF, 8'h5C, 2'd0, 16'h1FFF},
    {16'h2000, 8'h11, 2'd1, 16'h0000},
    {16'h2401, 8'h22, 2'd1, 16'h0001},
    {16'h2BFF, 8'h33, 2'd1, 16'h07FF},
    {16'h3EFF, 8'h44, 2'd1, 16'h06FF},
    {16'h3005, 8'h55, 2'd1, 16'h0005},
    {16'h3F00, 8'hFF, 2'd2, 16'h0000},
    {16'h3F10, 8'h2A, 2'd2, 16'h0000},
    {16'h3F11, 8'h07, 2'd2, 16'h0011},
    {16'h3F1C, 8'h09, 2'd2, 16'h000C},
    {16'h7F05, 8'hC3, 2'd2, 16'h0005},
    {16'hC123, 8'h66, 2'd0, 16'h0123}
  };

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_addr(input logic [15:0] a);
    @(negedge clk); addr_ld = 1'b1; addr_in = a;
    @(negedge clk); addr_ld = 1'b0;
  endtask

  task automatic set_step(input logic big);
    @(negedge clk); step_ld = 1'b1; step_sel = big;
    @(negedge clk); step_ld = 1'b0;
  endtask

  task automatic set_win(input logic [1:0] w, input logic [1:0] b);
    @(negedge clk); win_ld = 1'b1; win_sel = w; win_bank = b;
    @(negedge clk); win_ld = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    #1;
  endtask

  task automatic do_write(input logic [7:0] d, input logic fs);
    @(negedge clk); wr_en = 1'b1; wr_data = d; frame_start = fs;
    #1;
    c_pat = pat_we; c_nt = nt_we; c_pal = pal_we;
    c_pat_addr = pat_addr; c_nt_addr = nt_addr; c_wdata = mem_wdata;
    c_pidx = pal_idx; c_pdata = pal_wdata;
    @(negedge clk); wr_en = 1'b0; frame_start = 1'b0;
    #1;
  endtask

  task automatic pal_write(input logic [15:0] a, input logic [7:0] d,
                           input logic fs, input logic exp_flag, input string req);
    set_addr(a);
    do_write(d, fs);
    check(pal_changed == exp_flag, req, "pal_changed", 32'(pal_changed), 32'(exp_flag));
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_ld = 1'b0; step_ld = 1'b0; step_sel = 1'b0;
    win_ld = 1'b0; wr_en = 1'b0; frame_start = 1'b0;
    addr_in = '0; win_sel = '0; win_bank = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    check(vaddr == 16'h0, "R1", "vaddr", 32'(vaddr), 0);
    check(!pal_changed, "R1", "pal_changed", 32'(pal_changed), 0);
    check(!(pat_we || nt_we || pal_we), "R1", "strobes", {29'd0, pat_we, nt_we, pal_we}, 0);

    // Vector walk: R3 R4 R6 decode with default windows (R1), step 1 (R2)
    for (int i = 0; i < NV; i++) begin
      logic [15:0] va, ex;
      logic [7:0]  vd;
      logic [1:0]  vr;
      {va, vd, vr, ex} = VEC[i];
      set_addr(va);
      do_write(vd, 1'b0);
      check({c_pat, c_nt, c_pal} == {vr == 2'd0, vr == 2'd1, vr == 2'd2}, "R7",
            "strobe set", {29'd0, c_pat, c_nt, c_pal}, 32'(vr));
      case (vr)
        2'd0: begin
          check(c_pat_addr == ex[12:0], "R3", "pat_addr", 32'(c_pat_addr), 32'(ex));
          check(c_wdata == vd, "R3", "mem_wdata", 32'(c_wdata), 32'(vd));
        end
        2'd1: begin
          check(c_nt_addr == ex[11:0], "R4", "nt_addr", 32'(c_nt_addr), 32'(ex));
          check(c_wdata == vd, "R4", "mem_wdata", 32'(c_wdata), 32'(vd));
        end
        default: begin
          check(c_pidx == ex[4:0], "R6", "pal_idx", 32'(c_pidx), 32'(ex));
          check(c_pdata == vd[5:0], "R6", "pal_wdata", 32'(c_pdata), 32'(vd[5:0]));
        end
      endcase
      check(vaddr == 16'(va + 16'd1), "R2", "vaddr step 1", 32'(vaddr), 32'(16'(va + 16'd1)));
    end

    // R2 step of 32, back to 1, and 16-bit wrap
    set_step(1'b1);
    set_addr(16'h2000);
    do_write(8'h01, 1'b0);
    check(vaddr == 16'h2020, "R2", "vaddr step 32", 32'(vaddr), 32'h2020);
    do_write(8'h02, 1'b0);
    check(vaddr == 16'h2040, "R2", "vaddr step 32 again", 32'(vaddr), 32'h2040);
    set_addr(16'hFFF0);
    do_write(8'h03, 1'b0);
    check(vaddr == 16'h0010, "R2", "vaddr wrap 32", 32'(vaddr), 32'h0010);
    set_step(1'b0);
    set_addr(16'hFFFF);
    do_write(8'h04, 1'b0);
    check(vaddr == 16'h0000, "R2", "vaddr wrap 1", 32'(vaddr), 0);
    check(c_pal && c_pidx == 5'h1F, "R6", "pal_idx at 0x3FFF", 32'(c_pidx), 32'h1F);
    repeat (3) @(negedge clk);
    #1;
    check(vaddr == 16'h0000, "R2", "vaddr holds idle", 32'(vaddr), 0);

    // R5 window programming
    set_win(2'd3, 2'd3);
    set_addr(16'h2C05);
    do_write(8'h77, 1'b0);
    check(c_nt && c_nt_addr == 12'hC05, "R5", "nt_addr window 3", 32'(c_nt_addr), 32'hC05);
    set_win(2'd0, 2'd2);
    set_addr(16'h3001);
    do_write(8'h78, 1'b0);
    check(c_nt && c_nt_addr == 12'h801, "R5", "nt_addr window 0", 32'(c_nt_addr), 32'h801);

    // R8 palette change flag
    pulse_frame();
    check(!pal_changed, "R8", "cleared by frame_start", 32'(pal_changed), 0);
    pal_write(16'h3F02, 8'h00, 1'b0, 1'b0, "R8 same value");
    pal_write(16'h3F02, 8'hC0, 1'b0, 1'b0, "R6 truncated same value");
    pal_write(16'h3F02, 8'h15, 1'b0, 1'b1, "R8 differing value");
    repeat (3) @(negedge clk);
    #1;
    check(pal_changed, "R8", "sticky", 32'(pal_changed), 1);
    pulse_frame();
    check(!pal_changed, "R8", "cleared again", 32'(pal_changed), 0);
    pal_write(16'h3F02, 8'h15, 1'b0, 1'b0, "R8 rewrite same");
    pal_write(16'h3F14, 8'h15, 1'b0, 1'b1, "R6 alias write");
    pulse_frame();
    pal_write(16'h3F04, 8'h15, 1'b0, 1'b0, "R6 alias shares entry");
    pal_write(16'h3F06, 8'h01, 1'b1, 1'b1, "R8 set wins over frame_start");
    set_addr(16'h0100);
    do_write(8'hEE, 1'b0);
    check(pal_changed, "R8", "pattern write keeps flag", 32'(pal_changed), 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule